// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one processor bus transfer at a time over a bus that carries a 20-bit address and 16-bit data on shared lines. A requester presents a read or write, a memory or I/O selection, a word address, byte lanes and write data while the sequencer reports it is free. The sequencer then steps through four bus states (T1, T2, T3, T4). It pulses the address strobe, drives and floats the shared lines, phases the read, write and data-enable strobes, and sets the transceiver direction. When the cycle ends it returns the captured read data with a one-clock done pulse.

The block is clocked at twice the bus-state rate, so every bus state occupies two clocks: an early half (A) and a late half (B). Events that fall in the middle of a state land on the boundary between its two halves. These are the fall of the address strobe in T1, the assertion of the read strobe in T2 and the release of write data in T4. The addressed device stretches the cycle by holding `ready` low. Each low sample inserts a wait state (Tw) that repeats the T3 outputs.

Top module: `bus_cycle_seq`

## Requirements
- R1: During and after reset, with no cycle running: `ale`=0; `rd_n`, `wr_n`, `den_n`, `dt_r` and `bhe_n` are 1; `mio`, `done`, `ad_oe` and `a_hi_oe` are 0; `ad_o` and `a_hi_o` are 0; `req_rdy`=1.
- R2: A request is taken only on a clock edge where `req` and `req_rdy` are both 1. The first half of T1 follows on that edge. A `req` raised while a cycle runs is ignored: the running cycle is unchanged, and the sequencer is idle with `ale` low in the clock after the done pulse.
- R3: In both halves of T1, `ad_o` carries address bits 15..1 with the derived bit 0 in position 0, `a_hi_o` carries address bits 19..16, and both output enables are 1. `ale` is 1 only in the first half, so it falls while the address is still driven. `ad_o` and `a_hi_o` read 0 whenever their enable is 0.
- R4: Lane selection by `req_be` (bit 0 = low byte, bit 1 = high byte): 01 gives address bit 0 = 0 with `bhe_n`=1; 10 gives bit 0 = 1 with `bhe_n`=0; 11 and 00 both give bit 0 = 0 with `bhe_n`=0. `mio` (1 = memory) and `bhe_n` hold their values from T1 through T4.
- R5: In a read, `ad_oe` is 0 from the first half of T2 onward. `rd_n` and `den_n` are 0 from the second half of T2 through the last half of T3 or of the final Tw. `dt_r` is 0 for the whole read cycle.
- R6: In a write, `wr_n` and `den_n` go to 0 and the write data is driven from the first half of T2. `wr_n` returns to 1 at the start of T4. The data and `den_n`=0 are held through the first half of T4 and released in its second half. `dt_r` is 1.
- R7: `ready` is sampled at the edge that ends the second half of T3 and of each Tw. Each sample of 0 inserts one Tw (two clocks) with the same outputs as T3. A sample of 1 moves to T4.
- R8: Read data is captured from `ad_i` on the edge where `ready` is seen high, which is before `rd_n` rises. It appears on `rdata` with the done pulse and stays there until the next read captures.
- R9: `done` is 1 for exactly one clock, in the second half of T4. The sequencer is idle (`req_rdy`=1) in the next clock.
- R10: `rd_n` and `wr_n` are never 0 together, and `rd_n` is never 0 while `ad_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a bus cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_mio | input | 1 | 1 = memory, 0 = I/O |
| req_addr | input | 19 | Word address, bits 19..1 |
| req_be | input | 2 | Byte lanes (bit 0 low, bit 1 high) |
| req_wdata | input | 16 | Write data |
| req_rdy | output | 1 | Sequencer idle, request may be taken |
| ready | input | 1 | Device ready, sampled at end of T3/Tw |
| ad_i | input | 16 | Shared lines as seen from the bus |
| ad_o | output | 16 | Value driven onto shared lines |
| ad_oe | output | 1 | Drive enable for shared lines |
| a_hi_o | output | 4 | Upper address bits 19..16 |
| a_hi_oe | output | 1 | Drive enable for upper address |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable for transceivers, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| mio | output | 1 | Memory (1) or I/O (0) select |
| bhe_n | output | 1 | High byte enable, active low |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 16 | Captured read data |

## Verification
A wrong state register shows at the ports within one clock. Every strobe and enable is decoded from the current half-state, so a skipped or repeated half moves an edge of `ale`, `rd_n`, `wr_n` or `den_n` by one clock, or stretches the cycle. The bench compares the whole output vector at every half-state of every cycle, so such a slip is reported at the exact clock it occurs. A mistaken capture edge or ready sampling point shows up as stale `rdata` at the done pulse or as a wrong count of wait halves. The bench detects this by driving valid read data only in the single clock before the capture edge.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  // Half-state encoding: each bus state splits into an early (A) and late (B) half.
  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_T1A  = 4'd1,
    S_T1B  = 4'd2,
    S_T2A  = 4'd3,
    S_T2B  = 4'd4,
    S_T3A  = 4'd5,
    S_T3B  = 4'd6,
    S_TWA  = 4'd7,
    S_TWB  = 4'd8,
    S_T4A  = 4'd9,
    S_T4B  = 4'd10
  } bstate_t;

  typedef struct packed {
    logic wr;
    logic mio;
    logic a0;
    logic bhe_n;
  } cmd_t;

  // Byte lanes to {address bit 0, high-byte enable (active low)}.
  function automatic logic [1:0] lane_code(input logic [1:0] be);
    logic [1:0] r;
    case (be)
      2'b01:   r = 2'b01;
      2'b10:   r = 2'b10;
      default: r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    ready,
  output bstate_t st_q,
  output logic    accept,
  output logic    cap_en,
  output logic    done,
  output logic    idle
);

  bstate_t st_d;
  logic    sample_pt;

  assign idle      = (st_q == S_IDLE);
  assign accept    = idle & req;
  assign sample_pt = (st_q == S_T3B) | (st_q == S_TWB);
  assign cap_en    = sample_pt & ready;
  assign done      = (st_q == S_T4B);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:       if (req) st_d = S_T1A;
      S_T1A:        st_d = S_T1B;
      S_T1B:        st_d = S_T2A;
      S_T2A:        st_d = S_T2B;
      S_T2B:        st_d = S_T3A;
      S_T3A:        st_d = S_T3B;
      S_T3B, S_TWB: st_d = ready ? S_T4A : S_TWA;
      S_TWA:        st_d = S_TWB;
      S_T4A:        st_d = S_T4B;
      S_T4B:        st_d = S_IDLE;
      default:      st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  // R7: a low ready sample inserts a wait half pair.
  assert_wait_on_low_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && !ready) |=> (st_q == S_TWA));

  // R7: a high ready sample goes on to T4.
  assert_advance_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && ready) |=> (st_q == S_T4A));

  // R2: a cycle only ever starts from idle.
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_T1A) |-> $past(idle));

endmodule

// File: rtl/bus_seq_cmd.sv
module bus_seq_cmd
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_wr,
  input  logic              req_mio,
  input  logic [ADDR_W-1:1] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output cmd_t              cmd_q,
  output logic [ADDR_W-1:1] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic [1:0] lane;
  cmd_t       cmd_d;

  assign lane  = lane_code(req_be);
  assign cmd_d = '{wr: req_wr, mio: req_mio, a0: lane[1], bhe_n: lane[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '{wr: 1'b0, mio: 1'b0, a0: 1'b0, bhe_n: 1'b1};
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cmd_q   <= cmd_d;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  bstate_t           st,
  input  cmd_t              cmd,
  input  logic [ADDR_W-1:1] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic              a_hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              mio,
  output logic              bhe_n
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic in_cycle, in_t1, rd_win, wr_win, wd_win;
  logic [DATA_W-1:0] lo_addr;

  assign in_cycle = (st != S_IDLE);
  assign in_t1    = (st == S_T1A) | (st == S_T1B);
  // Read strobe window: late T2 through T3 and waits.
  assign rd_win   = (st == S_T2B) | (st == S_T3A) | (st == S_T3B) |
                    (st == S_TWA) | (st == S_TWB);
  // Write strobe window: from early T2.
  assign wr_win   = (st == S_T2A) | rd_win;
  // Write data window: held through early T4.
  assign wd_win   = wr_win | (st == S_T4A);

  assign lo_addr  = {addr_q[DATA_W-1:1], cmd.a0};

  always_comb begin
    ale     = (st == S_T1A);
    a_hi_oe = in_t1;
    a_hi_o  = in_t1 ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
    if (in_t1) begin
      ad_oe = 1'b1;
      ad_o  = lo_addr;
    end else if (cmd.wr && wd_win) begin
      ad_oe = 1'b1;
      ad_o  = wdata_q;
    end else begin
      ad_oe = 1'b0;
      ad_o  = '0;
    end
    rd_n  = ~(~cmd.wr & rd_win);
    wr_n  = ~(cmd.wr & wr_win);
    den_n = ~((~cmd.wr & rd_win) | (cmd.wr & wd_win));
    dt_r  = in_cycle ? cmd.wr : 1'b1;
    mio   = in_cycle & cmd.mio;
    bhe_n = in_cycle ? cmd.bhe_n : 1'b1;
  end

endmodule

// File: rtl/bus_seq_rdcap.sv
module bus_seq_rdcap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              is_wr,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] rdata
);

  logic load;
  assign load = cap_en & ~is_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata <= '0;
    else if (load) rdata <= ad_i;
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_mio,
  input  logic [ADDR_W-1:1] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_rdy,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic              a_hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dt_r,
  output logic              mio,
  output logic              bhe_n,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  bstate_t    st_q;
  logic       accept, cap_en;
  cmd_t       cmd_q;
  logic [ADDR_W-1:1] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  bus_seq_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .req    (req),
    .ready  (ready),
    .st_q   (st_q),
    .accept (accept),
    .cap_en (cap_en),
    .done   (done),
    .idle   (req_rdy)
  );

  bus_seq_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .accept    (accept),
    .req_wr    (req_wr),
    .req_mio   (req_mio),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .cmd_q     (cmd_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q)
  );

  bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .st      (st_q),
    .cmd     (cmd_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ad_o    (ad_o),
    .ad_oe   (ad_oe),
    .a_hi_o  (a_hi_o),
    .a_hi_oe (a_hi_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .den_n   (den_n),
    .dt_r    (dt_r),
    .mio     (mio),
    .bhe_n   (bhe_n)
  );

  bus_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .cap_en (cap_en),
    .is_wr  (cmd_q.wr),
    .ad_i   (ad_i),
    .rdata  (rdata)
  );

  // R3: external latches see the address stable when the strobe falls.
  assert_ale_fall_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(ale) |-> (ad_oe && a_hi_oe));

  // R4: select and lane signals hold for the whole cycle.
  assert_select_held_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!req_rdy && $past(!req_rdy)) |-> ($stable(mio) && $stable(bhe_n) && $stable(dt_r)));

  // R8: capture happens while the read strobe is still low.
  assert_capture_before_rd_rise_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cap_en && !dt_r) |-> !rd_n);

  // R9: done is a single pulse followed by idle.
  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> (req_rdy && !done));

  // R10: strobes never overlap and reads never contend with our drivers.
  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(!rd_n && !wr_n));
  assert_read_float_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_n |-> !ad_oe);

endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;

  logic        clk;
  logic        rst_n;
  logic        req, req_wr, req_mio;
  logic [19:1] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        req_rdy;
  logic        ready;
  logic [15:0] ad_i, ad_o;
  logic        ad_oe;
  logic [3:0]  a_hi_o;
  logic        a_hi_oe, ale, rd_n, wr_n, den_n, dt_r, mio, bhe_n, done;
  logic [15:0] rdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  bus_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_mio(req_mio),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_rdy(req_rdy),
    .ready(ready), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .a_hi_o(a_hi_o),
    .a_hi_oe(a_hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dt_r(dt_r), .mio(mio), .bhe_n(bhe_n), .done(done), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [30:0] pins();
    return {ale, ad_oe, ad_o, a_hi_oe, a_hi_o, rd_n, wr_n, den_n, dt_r, mio, bhe_n, done, req_rdy};
  endfunction

  localparam logic [30:0] IDLE_VEC = {1'b0, 1'b0, 16'h0, 1'b0, 4'h0,
                                      1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic run_cycle(input logic wr, input logic mo, input logic [19:1] addr,
                           input logic [1:0] be, input logic [15:0] wd, input int nw,
                           input logic [15:0] rdv, input bit poke);
    int lw, n;
    logic a0, bh;
    lw = 5 + 2 * nw;
    n  = lw + 3;
    case (be)
      2'b01:   begin a0 = 1'b0; bh = 1'b1; end
      2'b10:   begin a0 = 1'b1; bh = 1'b0; end
      default: begin a0 = 1'b0; bh = 1'b0; end
    endcase
    @(negedge clk);
    chk("R2 idle before request", {63'd0, req_rdy}, 64'd1);
    req = 1'b1; req_wr = wr; req_mio = mo; req_addr = addr; req_be = be;
    req_wdata = wd; ready = 1'b0; ad_i = ~rdv;
    for (int h = 0; h < n; h++) begin
      logic t1, rw, ww, dw, oe;
      logic [15:0] eo;
      logic [30:0] ev;
      string tag;
      @(negedge clk);
      if (h == 0) req = 1'b0;
      t1 = (h < 2);
      rw = !wr && h >= 3 && h <= lw;
      ww = wr && h >= 2 && h <= lw;
      dw = wr && h >= 2 && h <= lw + 1;
      oe = t1 | dw;
      eo = t1 ? {addr[15:1], a0} : (dw ? wd : 16'h0);
      ev = {(h == 0), oe, eo, t1, (t1 ? addr[19:16] : 4'h0), !rw, !ww, !(rw | dw),
            wr, mo, bh, (h == lw + 2), 1'b0};
      if (t1)                 tag = "R3 T1 phase";
      else if (h > 5 && h <= lw) tag = "R7 wait state";
      else if (h == lw + 2)   tag = "R9 done half";
      else if (wr)            tag = "R6 write phase";
      else                    tag = "R5 read phase";
      chk(tag, {33'd0, pins()}, {33'd0, ev});
      chk("R10 no strobe overlap or contention",
          {62'd0, (!rd_n && !wr_n), (!rd_n && ad_oe)}, 64'd0);
      if (h == 0) chk("R4 lane code", {62'd0, ad_o[0], bhe_n}, {62'd0, a0, bh});
      if (h == lw + 2 && !wr) chk("R8 read data at done", {48'd0, rdata}, {48'd0, rdv});
      if (poke && h == 4) begin
        req = 1'b1; req_addr = ~addr; req_wr = ~wr;
      end
      if (poke && h == n - 2) req = 1'b0;
      ready = (h == lw);
      ad_i  = (h == lw) ? rdv : ~rdv;
    end
    @(negedge clk);
    chk("R9 idle after done", {33'd0, pins()}, {33'd0, IDLE_VEC});
    if (!wr) chk("R8 read data held", {48'd0, rdata}, {48'd0, rdv});
    if (poke) begin
      @(negedge clk);
      chk("R2 busy request ignored", {33'd0, pins()}, {33'd0, IDLE_VEC});
    end
  endtask

  initial begin
    req = 0; req_wr = 0; req_mio = 0; req_addr = '0; req_be = 0; req_wdata = 0;
    ready = 0; ad_i = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", {33'd0, pins()}, {33'd0, IDLE_VEC});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {33'd0, pins()}, {33'd0, IDLE_VEC});
    for (int i = 0; i < 64; i++) begin
      logic [19:1] a;
      a = 19'h4A5B3 ^ 19'(i * 19'h2D1F);
      run_cycle(i[0], i[1], a, i[3:2], 16'h1357 + 16'(i * 16'h0F1D), i / 16,
                16'hC3A5 + 16'(i * 16'h1111), 1'b0);
    end
    run_cycle(1'b0, 1'b1, 19'h7FFFF, 2'b11, 16'h0, 2, 16'hBEEF, 1'b1);
    run_cycle(1'b1, 1'b0, 19'h00001, 2'b10, 16'hA55A, 0, 16'h0, 1'b1);
    run_cycle(1'b0, 1'b0, 19'h12345, 2'b01, 16'h0, 5, 16'h0F0F, 1'b0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule